// File: doc/BRIEF.md
# Serial Character Receiver with Stop-Bit Tolerance

This block takes a serial line and rebuilds characters from it: a low start bit, a fixed number of data bits (least significant first), an optional parity bit and a stop bit. Each finished character is handed out as a byte with a one-cycle valid strobe. The parity, framing and break flags are registered in the same cycle as the byte. The receiver has two bit-timing modes. In the oversampled mode, `clk_en` is a tick at 16 times the bit rate. In the synchronous mode, every enabled clock carries exactly one bit.

In synchronous mode, a tolerant option lets characters arrive without stop bits, so a link can adapt between rates by dropping them. A zero found where the stop bit belongs still raises a framing error. That zero is then taken as the first data bit of the next character, and no start bit precedes that character. Under this option, break is reported only on the second of two back-to-back all-zero characters that both lack a stop bit. A separate gating option makes the receiver deaf while a local transmit-active input is high. This keeps a node on a shared line from receiving its own transmission.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `rx_valid`, `rx_data`, `err_parity`, `err_frame` and `brk` are all 0.
- R2: With `cfg_sync`=1, one line bit is taken on every cycle with `clk_en`=1. A frame is a 0 start bit, 8 data bits LSB first, a parity bit only when `cfg_par_en`=1, and a stop bit. After the stop bit, `rx_valid` pulses for exactly one cycle, with the byte and all flags valid in that cycle.
- R3: With `cfg_sync`=0, `clk_en` is a 16x tick. A low line is confirmed as a start bit on the 8th tick after it is first seen low. Every later bit is sampled 16 ticks after the previous one. A low pulse that is high again at the confirmation point is discarded and yields no character.
- R4: `cfg_par_mode` selects the parity: 00 odd (data plus parity has an odd count of ones), 01 space (parity bit 0), 10 even, 11 mark (parity bit 1). `err_parity` is 1 when the received parity bit differs from the selected rule. It is always 0 when `cfg_par_en`=0.
- R5: Outside the tolerant option, a 0 in the stop position sets `err_frame` and ends the character. In oversampled mode, no new start is searched for until the line has been high again.
- R6: Outside the tolerant option, a character whose data bits (and parity bit, if enabled) are all 0 and whose stop bit is 0 sets `brk` together with `err_frame`.
- R7: With `cfg_sync`=1 and `cfg_zero_stop`=1, a 0 in the stop position sets `err_frame`. That 0 becomes data bit 0 of the next character, which then takes only its remaining data bits and no start bit.
- R8: Under the tolerant option, `brk` is set only for the second of two consecutive all-zero characters that both lack a stop bit. The first of them reports `err_frame`=1 and `brk`=0.
- R9: `cfg_zero_stop` has no effect when `cfg_sync`=0. Framing and break then behave as in R5 and R6.
- R10: While `cfg_gate_tx`=1 and `tx_active`=1, the line is ignored, any partial character is dropped and `rx_valid` stays 0. With `cfg_gate_tx`=0, `tx_active` has no effect.
- R11: In synchronous mode, no bit is taken on a cycle with `clk_en`=0, whatever the line level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Bit enable (synchronous) or 16x tick (oversampled) |
| rx_line | input | 1 | Serial data line, idle high |
| tx_active | input | 1 | Local transmitter busy indication |
| cfg_sync | input | 1 | 1: one bit per enabled clock; 0: 16x oversampling |
| cfg_zero_stop | input | 1 | Accept characters with missing stop bits (synchronous only) |
| cfg_par_en | input | 1 | A parity bit follows the data bits |
| cfg_par_mode | input | 2 | Parity rule: 00 odd, 01 space, 10 even, 11 mark |
| cfg_gate_tx | input | 1 | Ignore the line while `tx_active` is high |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe marking a new character |
| err_parity | output | 1 | Parity mismatch for the character on `rx_valid` |
| err_frame | output | 1 | Stop bit was 0 |
| brk | output | 1 | Break condition detected |

## Verification
A state machine that is off by one bit position shows up in the very next character. It either shifts the byte by one bit or misplaces the parity and stop samples, so `rx_data` and `err_frame` are wrong on the first `rx_valid`. A stale record of the previous all-zero character only shows up a character later, as a `brk` on the wrong member of a run. For that reason the runs of zero-stop characters are checked event by event. A receiver that keeps state through gating, or that re-arms too early after a framing error, produces an extra character. Counting every `rx_valid` pulse exposes this within one frame time.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    PM_ODD   = 2'b00,
    PM_SPACE = 2'b01,
    PM_EVEN  = 2'b10,
    PM_MARK  = 2'b11
  } par_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_st_e;

  // Parity bit the sender should have put on the line, given the XOR of the data.
  function automatic logic expect_parity(input logic data_xor, input par_mode_e mode);
    logic p;
    case (mode)
      PM_ODD:   p = ~data_xor;
      PM_SPACE: p = 1'b0;
      PM_EVEN:  p = data_xor;
      default:  p = 1'b1;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/srx_bit_timer.sv
module srx_bit_timer #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sync_mode,
  input  logic hold,
  input  logic hunt,
  input  logic line,
  input  logic release_i,
  output logic bit_stb,
  output logic bit_val
);
  localparam int CW       = $clog2(OVS);
  localparam int HALF_LIM = OVS / 2 - 1;
  localparam int FULL_LIM = OVS - 1;

  logic          armed;
  logic          first;
  logic          wait_high;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          async_stb;

  assign lim       = first ? CW'(HALF_LIM) : CW'(FULL_LIM);
  assign async_stb = armed && tick && (cnt == lim);
  assign bit_stb   = !hold && (sync_mode ? tick : async_stb);
  assign bit_val   = line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      first     <= 1'b0;
      wait_high <= 1'b0;
      cnt       <= '0;
    end else if (hold || sync_mode) begin
      armed     <= 1'b0;
      first     <= 1'b0;
      wait_high <= 1'b0;
      cnt       <= '0;
    end else if (tick) begin
      if (!armed) begin
        if (wait_high) begin
          if (line) wait_high <= 1'b0;
        end else if (hunt && !line) begin
          armed <= 1'b1;
          first <= 1'b1;
          cnt   <= CW'(1);
        end
      end else if (cnt == lim) begin
        cnt   <= '0;
        first <= 1'b0;
        if (release_i) begin
          armed     <= 1'b0;
          wait_high <= !line;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/srx_deframer.sv
module srx_deframer
  import srx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              par_en,
  input  logic              zs_eff,
  output logic              hunt,
  output logic              release_o,
  output logic              char_end,
  output logic [DATA_W-1:0] word,
  output logic              pbit
);
  localparam int IW = $clog2(DATA_W);

  rx_st_e        st;
  logic [IW-1:0] idx;
  logic          last_data;
  logic          chain;

  assign last_data = (idx == IW'(DATA_W - 1));
  assign hunt      = (st == ST_IDLE);
  assign char_end  = bit_stb && (st == ST_STOP);
  assign chain     = char_end && zs_eff && !bit_val;
  assign release_o = bit_stb && (((st == ST_IDLE) && bit_val) || (char_end && !chain));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      idx  <= '0;
      word <= '0;
      pbit <= 1'b0;
    end else if (hold) begin
      st  <= ST_IDLE;
      idx <= '0;
    end else if (bit_stb) begin
      unique case (st)
        ST_IDLE: begin
          if (!bit_val) begin
            st   <= ST_DATA;
            idx  <= '0;
            pbit <= 1'b0;
          end
        end
        ST_DATA: begin
          word <= {bit_val, word[DATA_W-1:1]};
          if (last_data) begin
            idx <= '0;
            st  <= par_en ? ST_PAR : ST_STOP;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_PAR: begin
          pbit <= bit_val;
          st   <= ST_STOP;
        end
        default: begin
          if (chain) begin
            st   <= ST_DATA;
            idx  <= IW'(1);
            pbit <= 1'b0;
            word <= {1'b0, word[DATA_W-1:1]};
          end else begin
            st <= ST_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/srx_status.sv
module srx_status
  import srx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              char_end,
  input  logic              stop_bit,
  input  logic [DATA_W-1:0] word,
  input  logic              pbit,
  input  logic              par_en,
  input  logic [1:0]        par_mode,
  input  logic              zs_eff,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              err_parity,
  output logic              err_frame,
  output logic              brk
);
  logic prev_zns;
  logic zero_char;
  logic no_stop;
  logic exp_p;
  logic brk_now;

  assign zero_char = (word == '0) && !(par_en && pbit);
  assign no_stop   = !stop_bit;
  assign exp_p     = expect_parity(^word, par_mode_e'(par_mode));
  assign brk_now   = zero_char && no_stop && (!zs_eff || prev_zns);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      err_parity <= 1'b0;
      err_frame  <= 1'b0;
      brk        <= 1'b0;
      prev_zns   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (hold) begin
        prev_zns <= 1'b0;
      end else if (char_end) begin
        rx_data    <= word;
        rx_valid   <= 1'b1;
        err_parity <= par_en && (pbit != exp_p);
        err_frame  <= no_stop;
        brk        <= brk_now;
        prev_zns   <= zero_char && no_stop;
      end
    end
  end

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              rx_line,
  input  logic              tx_active,
  input  logic              cfg_sync,
  input  logic              cfg_zero_stop,
  input  logic              cfg_par_en,
  input  logic [1:0]        cfg_par_mode,
  input  logic              cfg_gate_tx,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              err_parity,
  output logic              err_frame,
  output logic              brk
);
  logic              hold;
  logic              zs_eff;
  logic              bit_stb;
  logic              bit_val;
  logic              hunt;
  logic              release_w;
  logic              char_end;
  logic [DATA_W-1:0] word;
  logic              pbit;

  assign hold   = cfg_gate_tx && tx_active;
  assign zs_eff = cfg_sync && cfg_zero_stop;

  srx_bit_timer #(.OVS(OVS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (clk_en),
    .sync_mode (cfg_sync),
    .hold      (hold),
    .hunt      (hunt),
    .line      (rx_line),
    .release_i (release_w),
    .bit_stb   (bit_stb),
    .bit_val   (bit_val)
  );

  srx_deframer #(.DATA_W(DATA_W)) u_deframe (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (hold),
    .bit_stb   (bit_stb),
    .bit_val   (bit_val),
    .par_en    (cfg_par_en),
    .zs_eff    (zs_eff),
    .hunt      (hunt),
    .release_o (release_w),
    .char_end  (char_end),
    .word      (word),
    .pbit      (pbit)
  );

  srx_status #(.DATA_W(DATA_W)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .char_end   (char_end),
    .stop_bit   (bit_val),
    .word       (word),
    .pbit       (pbit),
    .par_en     (cfg_par_en),
    .par_mode   (cfg_par_mode),
    .zs_eff     (zs_eff),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .err_parity (err_parity),
    .err_frame  (err_frame),
    .brk        (brk)
  );

endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              tx_active,
  input logic              cfg_gate_tx,
  input logic              cfg_par_en,
  input logic              bit_stb,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              err_parity,
  input logic              err_frame,
  input logic              brk
);

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R2

  AST_NO_PAR_ERR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !$past(cfg_par_en)) |-> !err_parity); // R4

  AST_BRK_IS_ZERO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && brk) |-> (err_frame && (rx_data == '0))); // R6

  AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_gate_tx && tx_active) |=> !rx_valid); // R10

  AST_NO_BIT_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> clk_en); // R11

endmodule

bind serial_rx_core serial_rx_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clk_en      (clk_en),
  .tx_active   (tx_active),
  .cfg_gate_tx (cfg_gate_tx),
  .cfg_par_en  (cfg_par_en),
  .bit_stb     (bit_stb),
  .rx_data     (rx_data),
  .rx_valid    (rx_valid),
  .err_parity  (err_parity),
  .err_frame   (err_frame),
  .brk         (brk)
);

// File: tb/serial_rx_core_bench.sv
module serial_rx_core_bench;
  localparam int DW = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b0;
  logic       rx_line = 1'b1;
  logic       tx_active = 1'b0;
  logic       cfg_sync = 1'b1;
  logic       cfg_zero_stop = 1'b0;
  logic       cfg_par_en = 1'b0;
  logic [1:0] cfg_par_mode = 2'b00;
  logic       cfg_gate_tx = 1'b0;

  logic [DW-1:0] rx_data;
  logic          rx_valid, err_parity, err_frame, brk;

  serial_rx_core u_serial_rx_core (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .rx_line(rx_line),
    .tx_active(tx_active), .cfg_sync(cfg_sync), .cfg_zero_stop(cfg_zero_stop),
    .cfg_par_en(cfg_par_en), .cfg_par_mode(cfg_par_mode), .cfg_gate_tx(cfg_gate_tx),
    .rx_data(rx_data), .rx_valid(rx_valid), .err_parity(err_parity),
    .err_frame(err_frame), .brk(brk)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int ev_total = 0;
  int base = 0;
  logic [DW-1:0] ev_d [8];
  logic          ev_p [8];
  logic          ev_f [8];
  logic          ev_b [8];

  always @(negedge clk) begin
    if (rx_valid) begin
      ev_d[ev_total % 8] <= rx_data;
      ev_p[ev_total % 8] <= err_parity;
      ev_f[ev_total % 8] <= err_frame;
      ev_b[ev_total % 8] <= brk;
      ev_total <= ev_total + 1;
    end
  end

  // {par_en, mode[1:0], flip, data[7:0]}
  localparam logic [11:0] VEC [9] = '{
    12'h0A5, 12'h837, 12'h937, 12'hAFF, 12'hB00,
    12'hC81, 12'hD6E, 12'hE12, 12'hFC0
  };

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_count(string req, int n);
    chk(req, "character count", ev_total - base, n);
  endtask

  task automatic chk_ev(string req, int k, int d, int p, int f, int b);
    int slot = (base + k) % 8;
    chk(req, "data", int'(ev_d[slot]), d);
    chk(req, "parity error", int'(ev_p[slot]), p);
    chk(req, "frame error", int'(ev_f[slot]), f);
    chk(req, "break", int'(ev_b[slot]), b);
  endtask

  function automatic logic par_for(logic [7:0] d, logic [1:0] m);
    int ones = $countones(d);
    case (m)
      2'b00:   return (ones % 2) == 0;
      2'b01:   return 1'b0;
      2'b10:   return (ones % 2) == 1;
      default: return 1'b1;
    endcase
  endfunction

  task automatic sbit(logic b);
    @(negedge clk);
    rx_line = b;
    clk_en = 1'b1;
  endtask

  task automatic sidle(int n);
    repeat (n) sbit(1'b1);
  endtask

  task automatic sframe(logic [7:0] d, logic pen, logic [1:0] m, logic flip, logic stop);
    sbit(1'b0);
    for (int i = 0; i < 8; i++) sbit(d[i]);
    if (pen) sbit(par_for(d, m) ^ flip);
    sbit(stop);
  endtask

  task automatic abit(logic b);
    repeat (16) begin
      @(negedge clk);
      rx_line = b;
      clk_en = 1'b1;
    end
  endtask

  task automatic aframe(logic [7:0] d, logic stop);
    abit(1'b0);
    for (int i = 0; i < 8; i++) abit(d[i]);
    abit(stop);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "rx_valid", int'(rx_valid), 0);
    chk("R1", "rx_data", int'(rx_data), 0);
    chk("R1", "flags", int'({err_parity, err_frame, brk}), 0);
    rst_n = 1'b1;
    sidle(4);

    // R2 / R4: table of frames in synchronous mode
    foreach (VEC[i]) begin
      cfg_par_en   = VEC[i][11];
      cfg_par_mode = VEC[i][10:9];
      base = ev_total;
      sframe(VEC[i][7:0], VEC[i][11], VEC[i][10:9], VEC[i][8], 1'b1);
      sidle(3);
      chk_count("R2", 1);
      chk_ev("R4", 0, int'(VEC[i][7:0]), VEC[i][11] ? int'(VEC[i][8]) : 0, 0, 0);
    end
    cfg_par_en = 1'b0;

    // R5: missing stop in normal mode, then a clean frame
    base = ev_total;
    sframe(8'h5A, 1'b0, 2'b00, 1'b0, 1'b0);
    sidle(3);
    sframe(8'h33, 1'b0, 2'b00, 1'b0, 1'b1);
    sidle(3);
    chk_count("R5", 2);
    chk_ev("R5", 0, 8'h5A, 0, 1, 0);
    chk_ev("R5", 1, 8'h33, 0, 0, 0);

    // R6: all-zero character with zero stop, with and without even parity
    base = ev_total;
    sframe(8'h00, 1'b0, 2'b00, 1'b0, 1'b0);
    sidle(3);
    cfg_par_en = 1'b1;
    cfg_par_mode = 2'b10;
    sframe(8'h00, 1'b1, 2'b10, 1'b0, 1'b0);
    sidle(3);
    cfg_par_en = 1'b0;
    chk_count("R6", 2);
    chk_ev("R6", 0, 0, 0, 1, 1);
    chk_ev("R6", 1, 0, 0, 1, 1);

    // R7: zero in stop position becomes data bit 0 of next character
    cfg_zero_stop = 1'b1;
    base = ev_total;
    sbit(1'b0);
    for (int i = 0; i < 8; i++) sbit(8'h5A >> i);
    sbit(1'b0);
    for (int i = 1; i < 8; i++) sbit(8'h3C >> i);
    sbit(1'b1);
    sidle(3);
    chk_count("R7", 2);
    chk_ev("R7", 0, 8'h5A, 0, 1, 0);
    chk_ev("R7", 1, 8'h3C, 0, 0, 0);

    // R8: break only on the second consecutive zero character without stop
    base = ev_total;
    sbit(1'b0);
    repeat (8) sbit(1'b0);
    sbit(1'b0);
    repeat (7) sbit(1'b0);
    sbit(1'b0);
    repeat (7) sbit(1'b0);
    sbit(1'b1);
    sidle(3);
    chk_count("R8", 3);
    chk_ev("R8", 0, 0, 0, 1, 0);
    chk_ev("R8", 1, 0, 0, 1, 1);
    chk_ev("R8", 2, 0, 0, 0, 0);

    // R11: clk_en low cycles carry an inverted level and must be skipped
    cfg_zero_stop = 1'b0;
    base = ev_total;
    begin
      logic [9:0] fr = {1'b1, 8'hC3, 1'b0};
      for (int i = 0; i < 10; i++) begin
        @(negedge clk); rx_line = ~fr[i]; clk_en = 1'b0;
        @(negedge clk); rx_line = fr[i];  clk_en = 1'b1;
      end
    end
    sidle(3);
    chk_count("R11", 1);
    chk_ev("R11", 0, 8'hC3, 0, 0, 0);

    // R10: gated receiver drops a whole frame and a partial one
    cfg_gate_tx = 1'b1;
    tx_active = 1'b1;
    base = ev_total;
    sframe(8'h55, 1'b0, 2'b00, 1'b0, 1'b1);
    sidle(3);
    tx_active = 1'b0;
    sbit(1'b0);
    repeat (3) sbit(1'b1);
    @(negedge clk); tx_active = 1'b1;
    sidle(4);
    tx_active = 1'b0;
    sframe(8'h81, 1'b0, 2'b00, 1'b0, 1'b1);
    sidle(3);
    chk_count("R10", 1);
    chk_ev("R10", 0, 8'h81, 0, 0, 0);
    // R10: gate option off, tx_active has no effect
    cfg_gate_tx = 1'b0;
    tx_active = 1'b1;
    base = ev_total;
    sframe(8'h96, 1'b0, 2'b00, 1'b0, 1'b1);
    sidle(3);
    tx_active = 1'b0;
    chk_count("R10", 1);
    chk_ev("R10", 0, 8'h96, 0, 0, 0);

    // R3: oversampled mode, false start then real frame
    cfg_sync = 1'b0;
    sidle(20);
    base = ev_total;
    repeat (4) begin @(negedge clk); rx_line = 1'b0; end
    sidle(40);
    chk_count("R3", 0);
    aframe(8'h4B, 1'b1);
    sidle(24);
    chk_count("R3", 1);
    chk_ev("R3", 0, 8'h4B, 0, 0, 0);

    // R9: zero-stop option ignored in oversampled mode; R5 wait for high
    cfg_zero_stop = 1'b1;
    base = ev_total;
    aframe(8'h00, 1'b0);
    abit(1'b0);
    sidle(30);
    aframe(8'hE7, 1'b1);
    sidle(24);
    chk_count("R9", 2);
    chk_ev("R9", 0, 0, 0, 1, 1);
    chk_ev("R5", 1, 8'hE7, 0, 0, 0);

    finish_run();
  end

endmodule